// File: doc/BRIEF.md
# Change-of-state interrupt controller

This block watches thirty-two digital input lines and raises a single level interrupt when any of them changes in a direction that software has armed. Twenty-four of the lines are isolated field inputs and eight are TTL/CMOS lines. The lines form four groups of eight: isolated lines 0-7, 8-15 and 16-23 are groups 0, 1 and 2, and the TTL/CMOS lines are group 3. Each group can be armed for rising edges, falling edges, both or neither.

Every line passes through a two-flop synchronizer. An armed edge sets a sticky status bit for that line. Software reads the status bytes through a small synchronous register port. It then writes a mask back to clear only the events it has handled. The interrupt output stays high while any status bit is set.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset the edge-enable byte and all status bits are zero, `irq` is low and `rd_data` is zero.
- R2: Offset 0xE holds the edge-enable byte and can be read and written. Bit g (g = 0..3) arms rising edges for group g. Bit 4+g arms falling edges for group g.
- R3: A low-to-high change on a line whose group has its rising bit set sets that line's status bit. Reads of offsets 0x8, 0x9, 0xA and 0xB return the status of groups 0, 1, 2 and 3. Bit i of the byte is line 8g+i, and the TTL/CMOS lines are lines 24-31.
- R4: A high-to-low change on a line whose group has its falling bit set sets that line's status bit.
- R5: With both polarity bits of a group set, either direction sets status. With neither set, no edge on that group sets status.
- R6: Arming one group has no effect on the other groups.
- R7: A write to offset 0x8+g clears only the status bits of group g that are one in the written byte. All other status bits keep their value.
- R8: `irq` is high exactly when at least one status bit is set, and it only falls as the result of a clear write.
- R9: When a clear of a status bit and a new armed edge on the same line fall in the same cycle, the bit stays set.
- R10: Reads of offsets other than 0x8-0xB and 0xE return zero. Writes to those offsets change nothing.
- R11: An input level sampled at clock edge k produces its status bit, and `irq`, after edge k+2. `rd_data` shows the addressed byte in the cycle after `rd_en` and is zero otherwise.
- R12: A status bit stays set after the line returns to its former level, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 4 | Register byte offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| iso_in | input | 24 | Isolated input lines, groups 0-2 |
| ttl_in | input | 8 | TTL/CMOS lines, group 3 |
| irq | output | 1 | Level interrupt, OR of all status bits |

## Verification
Single isolated lines are raised and lowered under rising-only, falling-only, both and no polarity. This separates correct polarity qualification from plain change detection. A line toggled in a group that is not armed, and a mixed pattern across all four groups at once, show whether each group uses its own enable bits and whether the status bits land in the right byte and bit. A clear write that lands in the same cycle as a fresh edge on the same line shows whether events are lost. Partial-mask clears and accesses to unused offsets show that clears are bitwise and that unused addresses are inert.

// File: rtl/cos_pkg.sv
// Shared constants of the change-of-state interrupt controller.
// Assumes one data byte per register and four groups of eight lines.
package cos_pkg;
    localparam int COS_NGRP    = 4;   // groups of monitored lines
    localparam int COS_GW      = 8;   // lines per group
    localparam int COS_AW      = 4;   // register address width
    localparam int COS_DW      = 8;   // register data width
    localparam int COS_ST_BASE = 8;   // offset of the group 0 status byte
    localparam int COS_EN_ADDR = 14;  // offset of the edge-enable byte
endpackage

// File: rtl/cos_sync.sv
// Two-flop synchronizer for a bus of independent asynchronous lines.
// Assumes each line is quasi-static. No bus coherence is implied.
module cos_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Carry the raw lines through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/cos_group.sv
// Edge qualification and sticky status for one group of lines.
// Assumes synchronized inputs. The clear mask is one-hot per written bit.
// A new event wins over a clear of the same bit.
module cos_group #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] lines,
    input  logic          rise_en,
    input  logic          fall_en,
    input  logic [GW-1:0] clr,
    output logic [GW-1:0] status
);
    logic [GW-1:0] prev_q;
    logic [GW-1:0] ev;

    // Keep last cycle's synchronized levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    // Qualify edges by the group's polarity enables.
    always_comb begin
        ev = ((lines & ~prev_q) & {GW{rise_en}})
           | ((~lines & prev_q) & {GW{fall_en}});
    end

    // Sticky status: clear by mask, then set by new events.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | ev;
    end

    assert_keep_unwritten_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(status) & ~$past(clr))) & ~status) == '0));

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & clr) != '0) |=> ((status & $past(ev & clr)) == $past(ev & clr)));

    assert_disarmed_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_en && !fall_en) |=> ((status & ~$past(status)) == '0));
endmodule

// File: rtl/cos_regif.sv
// Register port: edge-enable byte, per-group clear masks, read mux.
// Assumes DW equals GW and equals twice the group count.
// Reads are registered and are zero without a read strobe.
module cos_regif
    import cos_pkg::*;
#(
    parameter int NGRP = COS_NGRP,
    parameter int GW   = COS_GW,
    parameter int AW   = COS_AW,
    parameter int DW   = COS_DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [NGRP*GW-1:0] status_flat,
    output logic [2*NGRP-1:0]  enable,
    output logic [NGRP*GW-1:0] clr_flat,
    output logic [DW-1:0]      rd_data
);
    localparam int EW = 2 * NGRP;

    logic          en_hit;
    logic          st_hit;
    logic [DW-1:0] rd_nxt;

    assign en_hit = (addr == AW'(COS_EN_ADDR));
    assign st_hit = (addr >= AW'(COS_ST_BASE)) && (addr < AW'(COS_ST_BASE + NGRP));

    // Hold the edge-enable byte.
    always_ff @(posedge clk) begin
        if (!rst_n)               enable <= '0;
        else if (wr_en && en_hit) enable <= wr_data[EW-1:0];
    end

    // Steer a status write into a one-cycle clear mask for its group.
    for (genvar g = 0; g < NGRP; g++) begin : g_clr
        assign clr_flat[g*GW +: GW] =
            (wr_en && addr == AW'(COS_ST_BASE + g)) ? wr_data[GW-1:0] : '0;
    end

    // Select the addressed byte; unused offsets give zero.
    always_comb begin
        rd_nxt = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (addr == AW'(COS_ST_BASE + g)) rd_nxt = DW'(status_flat[g*GW +: GW]);
        end
        if (en_hit) rd_nxt = DW'(enable);
    end

    // Register the read result for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_nxt;
        else            rd_data <= '0;
    end

    assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(COS_EN_ADDR)) |=> (enable == $past(wr_data[EW-1:0])));

    assert_unused_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !st_hit && !en_hit) |=> (rd_data == '0));

    assert_unused_write_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !st_hit && !en_hit) |=> $stable(enable));
endmodule

// File: rtl/cos_irq_ctrl.sv
// Top of the change-of-state interrupt controller.
// Assumes isolated lines fill groups 0..NGRP-2 and the TTL/CMOS lines form
// the last group. irq is the OR of every sticky status bit.
module cos_irq_ctrl
    import cos_pkg::*;
#(
    parameter int NGRP = COS_NGRP,
    parameter int GW   = COS_GW,
    parameter int AW   = COS_AW,
    parameter int DW   = COS_DW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wr_data,
    output logic [DW-1:0]         rd_data,
    input  logic [(NGRP-1)*GW-1:0] iso_in,
    input  logic [GW-1:0]         ttl_in,
    output logic                  irq
);
    localparam int NL = NGRP * GW;

    logic [NL-1:0]     sync_lines;
    logic [NL-1:0]     status_flat;
    logic [NL-1:0]     clr_flat;
    logic [2*NGRP-1:0] enable;

    cos_sync #(.W(NL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ttl_in, iso_in}),
        .q     (sync_lines)
    );

    cos_regif #(.NGRP(NGRP), .GW(GW), .AW(AW), .DW(DW)) u_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wr_data     (wr_data),
        .status_flat (status_flat),
        .enable      (enable),
        .clr_flat    (clr_flat),
        .rd_data     (rd_data)
    );

    // One edge detector and status byte per group.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        cos_group #(.GW(GW)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .lines   (sync_lines[g*GW +: GW]),
            .rise_en (enable[g]),
            .fall_en (enable[NGRP+g]),
            .clr     (clr_flat[g*GW +: GW]),
            .status  (status_flat[g*GW +: GW])
        );
    end

    // Merge all status bits into the interrupt level.
    assign irq = |status_flat;

    assert_irq_falls_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en));
endmodule

// File: tb/cos_irq_ctrl_tb.sv
module cos_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [3:0]  addr;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data;
    logic [23:0] iso_in;
    logic [7:0]  ttl_in;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit started = 0;
    bit done = 0;

    // Behavioural reference state.
    logic [31:0] m_stat;
    logic [7:0]  m_en;
    logic [7:0]  m_rd;
    logic [31:0] hist[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cos_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .iso_in(iso_in), .ttl_in(ttl_in),
        .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model: advances on every rising edge.
    always @(posedge clk) begin
        logic [31:0] ev, clr;
        logic [7:0]  rv;
        int a;
        started = 1;
        if (!rst_n) begin
            m_en = 0; m_stat = 0; m_rd = 0;
            hist = '{32'd0, 32'd0, 32'd0};
        end else begin
            a = int'(addr);
            rv = 0;
            if (rd_en) begin
                if (a >= 8 && a <= 11) rv = m_stat[(a-8)*8 +: 8];
                else if (a == 14)      rv = m_en;
            end
            for (int b = 0; b < 32; b++) begin
                ev[b]  = (hist[1][b] && !hist[2][b] && m_en[b/8])
                      || (!hist[1][b] && hist[2][b] && m_en[4 + b/8]);
                clr[b] = wr_en && (a == 8 + b/8) && wr_data[b%8];
            end
            m_stat = (m_stat & ~clr) | ev;
            if (wr_en && a == 14) m_en = wr_data;
            m_rd = rv;
            hist.push_front({ttl_in, iso_in});
            void'(hist.pop_back());
        end
    end

    // Compare against the model on every cycle, away from the edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check("R8", "irq vs model", {31'd0, irq}, {31'd0, (m_stat != 0)});
            check("R11", "rd_data vs model", {24'd0, rd_data}, {24'd0, m_rd});
        end
    end

    // All tasks start and end just after a falling edge.
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0; addr = 0; wr_data = 0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
        rd_en = 1; addr = a;
        @(negedge clk);
        check(req, $sformatf("read offset %h", a), {24'd0, rd_data}, {24'd0, exp});
        rd_en = 0; addr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wr_data = 0;
        iso_in = 0; ttl_in = 0;
        tick(4);
        rst_n = 1;
        tick(1);

        // R1: reset state
        check("R1", "irq after reset", {31'd0, irq}, 32'd0);
        check("R1", "rd_data after reset", {24'd0, rd_data}, 32'd0);
        rd("R1", 4'hE, 8'h00);
        for (int g = 0; g < 4; g++) rd("R1", 4'(8 + g), 8'h00);

        // R10: unused offsets
        wr(4'h5, 8'hFF);
        wr(4'hC, 8'hFF);
        rd("R10", 4'h5, 8'h00);
        rd("R10", 4'hC, 8'h00);
        rd("R10", 4'hE, 8'h00);

        // R2: enable byte read/write
        wr(4'hE, 8'hA5);
        rd("R2", 4'hE, 8'hA5);
        wr(4'hE, 8'h01);
        rd("R2", 4'hE, 8'h01);

        // R3 and R11: rising edge on line 3, two-cycle latency
        iso_in[3] = 1;
        tick(1); check("R11", "irq after edge k", {31'd0, irq}, 32'd0);
        tick(1); check("R11", "irq after edge k+1", {31'd0, irq}, 32'd0);
        tick(1); check("R11", "irq after edge k+2", {31'd0, irq}, 32'd1);
        rd("R3", 4'h8, 8'h08);

        // R12: line falls back, status sticks (falling disarmed)
        iso_in[3] = 0;
        tick(4);
        rd("R12", 4'h8, 8'h08);

        // R6: group 1 not armed
        iso_in[10] = 1;
        tick(4);
        rd("R6", 4'h9, 8'h00);

        // R7 and R8: partial clear
        iso_in[5] = 1;
        tick(4);
        rd("R3", 4'h8, 8'h28);
        wr(4'h8, 8'h08);
        rd("R7", 4'h8, 8'h20);
        check("R8", "irq with one bit left", {31'd0, irq}, 32'd1);
        wr(4'h8, 8'h20);
        check("R8", "irq after last clear", {31'd0, irq}, 32'd0);

        // R4: falling only on TTL group
        wr(4'hE, 8'h80);
        ttl_in[2] = 1;
        tick(4);
        rd("R4", 4'hB, 8'h00);
        ttl_in[2] = 0;
        tick(4);
        rd("R4", 4'hB, 8'h04);
        wr(4'hB, 8'h04);

        // R5: both polarities on group 2
        wr(4'hE, 8'h44);
        iso_in[17] = 1;
        tick(4);
        rd("R5", 4'hA, 8'h02);
        wr(4'hA, 8'h02);
        iso_in[17] = 0;
        tick(4);
        rd("R5", 4'hA, 8'h02);
        wr(4'hA, 8'h02);

        // R5: nothing armed, toggles are ignored
        wr(4'hE, 8'h00);
        iso_in[7:0] = 8'hFF; tick(4);
        iso_in[7:0] = 8'h00; tick(4);
        rd("R5", 4'h8, 8'h00);
        check("R5", "irq with nothing armed", {31'd0, irq}, 32'd0);

        // R9: clear and new edge in the same cycle
        wr(4'hE, 8'h08);
        ttl_in[0] = 1; tick(4);
        rd("R9", 4'hB, 8'h01);
        ttl_in[0] = 0; tick(4);
        ttl_in[0] = 1;
        tick(2);
        wr(4'hB, 8'h01);
        rd("R9", 4'hB, 8'h01);
        check("R9", "irq kept", {31'd0, irq}, 32'd1);
        wr(4'hB, 8'h01);
        check("R8", "irq after clear", {31'd0, irq}, 32'd0);

        // R3 and R6: all groups at once
        wr(4'hE, 8'h00);
        iso_in = 0; ttl_in = 0;
        tick(4);
        wr(4'hE, 8'h0F);
        iso_in = 24'h81_42_18; ttl_in = 8'hF0;
        tick(4);
        rd("R3", 4'h8, 8'h18);
        rd("R3", 4'h9, 8'h42);
        rd("R3", 4'hA, 8'h81);
        rd("R6", 4'hB, 8'hF0);
        wr(4'h8, 8'hFF); wr(4'h9, 8'hFF); wr(4'hA, 8'hFF); wr(4'hB, 8'hFF);
        check("R8", "irq after clearing all", {31'd0, irq}, 32'd0);

        tick(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule